// File: doc/BRIEF.md
# Test-Port Data Registers with Boundary Chain

This block implements the data-register half of an IEEE 1149.1 test port for a synchronous memory device. Three data registers are provided: a 32-bit identification register, a single-bit bypass register and a boundary chain whose length is set by a parameter. A 16-state TAP controller and a 3-bit instruction register are included, so the block can be exercised from the four test pins alone.

In the boundary chain, most cells sample a device pin level from a parallel input vector. Some cells are placeholders: they always capture 1 and ignore their pin. A mask parameter marks which cells are placeholders. The identification code carries the die revision and the vendor field. It also carries a field that tells whether the device is built as the 18-bit or the 36-bit I/O variant; a parameter picks the variant.

Top module: `jtag_scan_regs`

## Requirements
- R1: `trst_n` low resets the controller asynchronously to Test-Logic-Reset. Five consecutive TCK rising edges with TMS high also reach Test-Logic-Reset from any state.
- R2: In Test-Logic-Reset the current instruction becomes IDCODE (code 001).
- R3: With IDCODE current, Capture-DR loads this constant into the ID register: bit 0 = 1, bits 11:1 = vendor field, bits 15:12 = I/O width code (0001 for the 36-bit variant, 0010 for the 18-bit variant), bits 27:16 = 0, bits 31:28 = die revision.
- R4: In Shift-DR the selected register shifts one place toward TDO on each TCK rising edge. TDI enters the most significant cell. Bit 0 is the first bit to appear on TDO.
- R5: Instruction codes 000 and 100 select the boundary chain. In Capture-DR each non-placeholder cell i loads `pin_lvl[i]`.
- R6: A boundary cell whose bit is set in the placeholder mask captures 1, whatever its pin level.
- R7: Code 111 and every other code not named in R2 or R5 (including 010) select the bypass register. It captures 0 in Capture-DR and delays TDI by one shift.
- R8: TDO and `tdo_oe` change only on TCK falling edges. `tdo_oe` is high exactly while the controller is in Shift-DR or Shift-IR. TDO is 0 when `tdo_oe` is low.
- R9: The instruction register captures 001 in Capture-IR and shifts least significant bit first. The shifted code becomes current when the controller leaves Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on TCK rising edge |
| tdi | input | 1 | Serial test data in |
| pin_lvl | input | BSR_LEN | Sampled pin levels, bit i feeds boundary cell i |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | High while TDO carries shift data |

## Verification
The assertions assume that TMS, TDI and `pin_lvl` are stable around each TCK rising edge. They also assume that `trst_n` is released away from a rising edge, so that the captured values and the shift neighbours they compare against are well defined. The bench changes every input one time unit after a falling edge and holds it for the rest of the cycle. It keeps `pin_lvl` constant from before Capture-DR until the register has been read out. It releases `trst_n` in the low phase of TCK.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [OP_W-1:0] OP_IDCODE  = 3'b001;
   localparam logic [OP_W-1:0] OP_SAMPLEZ = 3'b010;
   localparam logic [OP_W-1:0] OP_SAMPLE  = 3'b100;
   localparam logic [OP_W-1:0] OP_BYPASS  = 3'b111;
   localparam logic [OP_W-1:0] IR_CAPTURE = 3'b001;

   typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} dr_sel_t;

   function automatic dr_sel_t dr_decode(input logic [OP_W-1:0] op);
      dr_sel_t s;
      case (op)
         OP_IDCODE:            s = DR_IDENT;
         OP_EXTEST, OP_SAMPLE: s = DR_BOUNDARY;
         default:              s = DR_BYPASS;
      endcase
      return s;
   endfunction

   function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
      tap_state_t n;
      case (s)
         ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import scan_port_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/instr_reg.sv
module instr_reg
   import scan_port_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic [OP_W-1:0] ir_cur,
   output logic [OP_W-1:0] ir_sr,
   output logic            ir_out
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr  <= IR_CAPTURE;
         ir_cur <= OP_IDCODE;
      end else begin
         case (state)
            ST_RESET:  ir_cur <= OP_IDCODE;
            ST_CAP_IR: ir_sr  <= IR_CAPTURE;
            ST_SHF_IR: ir_sr  <= {tdi, ir_sr[OP_W-1:1]};
            ST_UPD_IR: ir_cur <= ir_sr;
            default: ;
         endcase
      end
   end

   assign ir_out = ir_sr[0];

endmodule

// File: rtl/data_regs.sv
module data_regs
   import scan_port_pkg::*;
#(
   parameter int                  BSR_LEN = 24,
   parameter logic [BSR_LEN-1:0]  PH_MASK = '0,
   parameter logic [31:0]         ID_CODE = 32'h0000_0001
) (
   input  logic               tck,
   input  logic               trst_n,
   input  tap_state_t         state,
   input  dr_sel_t            sel,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_lvl,
   output logic [BSR_LEN-1:0] bsr_q,
   output logic [31:0]        id_q,
   output logic               byp_q,
   output logic               dr_out
);

   logic cap, shf;
   assign cap = (state == ST_CAP_DR);
   assign shf = (state == ST_SHF_DR);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_q <= ID_CODE;
      end else if (sel == DR_IDENT) begin
         if (cap)      id_q <= ID_CODE;
         else if (shf) id_q <= {tdi, id_q[31:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q <= 1'b0;
      end else if (sel == DR_BYPASS) begin
         if (cap)      byp_q <= 1'b0;
         else if (shf) byp_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         bsr_q <= PH_MASK;
      end else if (sel == DR_BOUNDARY) begin
         if (cap)      bsr_q <= pin_lvl | PH_MASK;
         else if (shf) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
      end
   end

   always_comb begin
      case (sel)
         DR_IDENT:    dr_out = id_q[0];
         DR_BOUNDARY: dr_out = bsr_q[0];
         default:     dr_out = byp_q;
      endcase
   end

endmodule

// File: rtl/jtag_scan_regs.sv
module jtag_scan_regs
   import scan_port_pkg::*;
#(
   parameter int                 BSR_LEN   = 24,
   parameter logic [BSR_LEN-1:0] PH_MASK   = 24'h80_4201,
   parameter logic [10:0]        VENDOR_ID = 11'h1B5,
   parameter logic [3:0]         DIE_REV   = 4'h3,
   parameter bit                 IO_X36    = 1'b1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_lvl,
   output logic               tdo,
   output logic               tdo_oe
);

   localparam logic [3:0] IO_CODE_X36 = 4'b0001;
   localparam logic [3:0] IO_CODE_X18 = 4'b0010;
   localparam logic [3:0] IO_CODE     = IO_X36 ? IO_CODE_X36 : IO_CODE_X18;
   localparam logic [31:0] ID_CODE    = {DIE_REV, 12'h000, IO_CODE, VENDOR_ID, 1'b1};

   generate
      if (BSR_LEN < 2) begin : g_len_bad
         $error("jtag_scan_regs: BSR_LEN must be at least 2");
      end
      if (PH_MASK == {BSR_LEN{1'b1}}) begin : g_mask_bad
         $error("jtag_scan_regs: boundary chain needs at least one pin cell");
      end
   endgenerate

   tap_state_t        tap_st;
   logic [OP_W-1:0]   ir_cur, ir_sr;
   logic              ir_out;
   dr_sel_t           dr_sel;
   logic [BSR_LEN-1:0] bsr_q;
   logic [31:0]       id_q;
   logic              byp_q, dr_out;
   logic              tdo_q, oe_q;

   tap_fsm i_fsm (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_st)
   );

   instr_reg i_ir (
      .tck(tck), .trst_n(trst_n), .state(tap_st), .tdi(tdi),
      .ir_cur(ir_cur), .ir_sr(ir_sr), .ir_out(ir_out)
   );

   assign dr_sel = dr_decode(ir_cur);

   data_regs #(
      .BSR_LEN(BSR_LEN), .PH_MASK(PH_MASK), .ID_CODE(ID_CODE)
   ) i_dr (
      .tck(tck), .trst_n(trst_n), .state(tap_st), .sel(dr_sel), .tdi(tdi),
      .pin_lvl(pin_lvl), .bsr_q(bsr_q), .id_q(id_q), .byp_q(byp_q), .dr_out(dr_out)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= (tap_st == ST_SHF_DR) || (tap_st == ST_SHF_IR);
         if (tap_st == ST_SHF_IR)      tdo_q <= ir_out;
         else if (tap_st == ST_SHF_DR) tdo_q <= dr_out;
         else                          tdo_q <= 1'b0;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = oe_q;

endmodule

// File: rtl/jtag_scan_regs_chk.sv
module jtag_scan_regs_chk
   import scan_port_pkg::*;
#(
   parameter int                 BSR_LEN = 24,
   parameter logic [BSR_LEN-1:0] PH_MASK = '0,
   parameter logic [3:0]         DIE_REV = 4'h0
) (
   input logic               tck,
   input logic               trst_n,
   input logic               tdi,
   input logic               tdo,
   input logic               tdo_oe,
   input logic [BSR_LEN-1:0] pin_lvl,
   input tap_state_t         tap_st,
   input logic [OP_W-1:0]    ir_cur,
   input logic [OP_W-1:0]    ir_sr,
   input logic [BSR_LEN-1:0] bsr_q,
   input logic [31:0]        id_q,
   input logic               byp_q
);

   logic bnd_op, byp_op;
   assign bnd_op = (ir_cur == OP_EXTEST) || (ir_cur == OP_SAMPLE);
   assign byp_op = !bnd_op && (ir_cur != OP_IDCODE);

   assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_RESET) |=> (ir_cur == OP_IDCODE));

   assert_id_fields_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_CAP_DR && ir_cur == OP_IDCODE) |=>
      (id_q[0] && id_q[27:16] == 12'h000 && id_q[31:28] == DIE_REV));

   assert_bsr_shift_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_SHF_DR && bnd_op) |=>
      (bsr_q == {$past(tdi), $past(bsr_q[BSR_LEN-1:1])}));

   assert_pin_capture_R5: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_CAP_DR && bnd_op) |=>
      ((bsr_q & ~PH_MASK) == ($past(pin_lvl) & ~PH_MASK)));

   assert_placeholder_R6: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_CAP_DR && bnd_op) |=> ((bsr_q & PH_MASK) == PH_MASK));

   assert_bypass_capture_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_CAP_DR && byp_op) |=> !byp_q);

   assert_bypass_shift_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_SHF_DR && byp_op) |=> (byp_q == $past(tdi)));

   assert_oe_window_R8: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (tap_st == ST_SHF_DR || tap_st == ST_SHF_IR));

   assert_tdo_quiet_R8: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_oe |-> !tdo);

   assert_ir_update_R9: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_st == ST_UPD_IR) |=> (ir_cur == $past(ir_sr)));

endmodule

bind jtag_scan_regs jtag_scan_regs_chk #(
   .BSR_LEN(BSR_LEN), .PH_MASK(PH_MASK), .DIE_REV(DIE_REV)
) i_chk (
   .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
   .pin_lvl(pin_lvl), .tap_st(tap_st), .ir_cur(ir_cur), .ir_sr(ir_sr),
   .bsr_q(bsr_q), .id_q(id_q), .byp_q(byp_q)
);

// File: tb/test_jtag_scan_regs.sv
module test_jtag_scan_regs;

   localparam int          LEN   = 24;
   localparam logic [23:0] MASK  = 24'h80_4201;
   localparam logic [31:0] EXP_ID = {4'h3, 12'h000, 4'b0001, 11'h1B5, 1'b1};
   localparam int          NVEC  = 6;
   localparam logic [2:0]  VOP  [NVEC] = '{3'b100, 3'b100, 3'b000, 3'b100, 3'b000, 3'b100};
   localparam logic [23:0] VPIN [NVEC] = '{24'h000000, 24'hFFFFFF, 24'hA5A5A5,
                                           24'h5A5A5A, 24'h123456, 24'h7FBDFE};

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic [LEN-1:0] pin_lvl = '0;
   logic tdo, tdo_oe;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 tck = ~tck;

   jtag_scan_regs i_jtag_scan_regs (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .pin_lvl(pin_lvl), .tdo(tdo), .tdo_oe(tdo_oe)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
      o = tdo;
   endtask

   task automatic read_dr(input int n, input logic [63:0] din,
                          output logic [63:0] dout, output logic oe_seen);
      logic b;
      dout = '0;
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      dout[0] = b;
      oe_seen = tdo_oe;
      for (int i = 1; i < n; i++) begin
         step(1'b0, din[i-1], b);
         dout[i] = b;
      end
      step(1'b1, din[n-1], b);
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
   endtask

   task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
      logic b;
      step(1'b1, 1'b0, b);
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b); cap[0] = b;
      step(1'b0, op[0], b); cap[1] = b;
      step(1'b0, op[1], b); cap[2] = b;
      step(1'b1, op[2], b);
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
   endtask

   initial begin
      logic [63:0] got;
      logic        oe;
      logic [2:0]  irc;
      logic        b;
      logic [LEN-1:0] expv;

      repeat (3) @(negedge tck);
      #1;
      check(tdo_oe == 1'b0 && tdo == 1'b0, "R8 reset quiet", {62'd0, tdo_oe, tdo}, 64'd0);
      trst_n = 1'b1;
      step(1'b0, 1'b0, b);

      // R2, R3, R4: IDCODE current after reset, read LSB first
      read_dr(32, 64'd0, got, oe);
      check(got[31:0] == EXP_ID, "R2/R3/R4 idcode after reset", got, {32'd0, EXP_ID});
      check(oe == 1'b1, "R8 oe in Shift-DR", {63'd0, oe}, 64'd1);
      check(tdo_oe == 1'b0, "R8 oe low in Run-Test/Idle", {63'd0, tdo_oe}, 64'd0);

      // R5, R6: vector table over boundary instructions
      for (int v = 0; v < NVEC; v++) begin
         load_ir(VOP[v], irc);
         if (v == 0) check(irc == 3'b001, "R9 IR capture pattern", {61'd0, irc}, 64'd1);
         pin_lvl = VPIN[v];
         read_dr(LEN, 64'd0, got, oe);
         expv = VPIN[v] | MASK;
         check((got[LEN-1:0] & ~MASK) == (expv & ~MASK), "R5 pin capture",
               got, {40'd0, expv});
         check((got[LEN-1:0] & MASK) == MASK, "R6 placeholder ones",
               {40'd0, got[LEN-1:0] & MASK}, {40'd0, MASK});
      end

      // R7: bypass via 111, unused 011 and 010
      load_ir(3'b111, irc);
      read_dr(8, 64'hB3, got, oe);
      check(got[7:0] == 8'h66, "R7 bypass 111", got, 64'h66);
      load_ir(3'b011, irc);
      read_dr(8, 64'h5C, got, oe);
      check(got[7:0] == 8'hB8, "R7 unused code 011", got, 64'hB8);
      load_ir(3'b010, irc);
      read_dr(8, 64'hFF, got, oe);
      check(got[7:0] == 8'hFE, "R7 code 010 bypass", got, 64'hFE);

      // R1, R2: five TMS-high clocks return to reset and restore IDCODE
      load_ir(3'b111, irc);
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      read_dr(32, 64'd0, got, oe);
      check(got[31:0] == EXP_ID, "R1/R2 TMS reset restores IDCODE", got, {32'd0, EXP_ID});

      // R1: asynchronous trst_n in the middle of Shift-DR
      load_ir(3'b100, irc);
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      trst_n = 1'b0;
      #1;
      check(tdo_oe == 1'b0, "R1/R8 trst clears oe", {63'd0, tdo_oe}, 64'd0);
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      step(1'b0, 1'b0, b);
      read_dr(32, 64'd0, got, oe);
      check(got[31:0] == EXP_ID, "R1 trst restores IDCODE", got, {32'd0, EXP_ID});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule